// File: doc/BRIEF.md
# Packed 4x4 Lane Transpose Unit

This block permutes the 16-bit lanes of four 128-bit rows. Each row carries eight lanes, with lane k in bits [16k+15:16k]. In its main mode the four rows form a 4x8 tile, and the unit transposes the two 4x4 sub-blocks of that tile on their own. Lanes 0-3 of the four rows are one sub-block and lanes 4-7 are the other. No element ever moves from one sub-block to the other.

Three further modes cover other uses. Two of them interleave pairs of rows, one using the even lanes and one using the odd lanes, for general lane shuffling. The last mode passes the rows through unchanged.

A valid/ready handshake accepts one tile with its 2-bit mode. The permuted result is registered and is offered on the output one cycle later. A two-state controller tracks the output register:
- **HOLD_EMPTY**: the output register holds no result.
- **HOLD_FULL**: the output register holds a result that the consumer has not yet taken.

The controller has four transitions:
- **FILL** (HOLD_EMPTY to HOLD_FULL): an input is accepted.
- **DRAIN** (HOLD_FULL to HOLD_EMPTY): the consumer takes the result and no new input is accepted.
- **REFILL** (HOLD_FULL to HOLD_FULL): the consumer takes the result and a new input is accepted in the same cycle.
- **STALL** (HOLD_FULL to HOLD_FULL): the consumer is not ready, so the result is held and no input is accepted.

Top module: `lane_xpose_unit`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. Whenever out_valid is 0, in_ready is 1.
- R2: An input accepted at a clock edge (in_valid and in_ready both 1) shows as out_valid = 1 after that edge, carrying the permuted rows of that input.
- R3: While out_valid is 1 and out_ready is 0, in_ready is 0, and the output rows and out_valid stay unchanged at the next edge.
- R4: Mode 2'b00 (transpose) sets output row N, lane i, to element (i mod 4)*8 + (i - i mod 4) + N of the input. Input elements are numbered row*8 + lane.
- R5: In transpose mode, output lanes 0-3 depend only on input lanes 0-3, and output lanes 4-7 depend only on input lanes 4-7.
- R6: Mode 2'b01 (even interleave) pairs row N with partner row N^1. Output row N, lane 2k, is lane 2k of row N. Output row N, lane 2k+1, is lane 2k of row N^1.
- R7: Mode 2'b10 (odd interleave) also pairs row N with row N^1. Output row N, lane 2k, is lane 2k+1 of row N. Output row N, lane 2k+1, is lane 2k+1 of row N^1.
- R8: Mode 2'b11 returns the four rows unchanged.
- R9: Feeding a transpose-mode result back in transpose mode gives the original tile.
- R10: When out_valid and out_ready are both 1 and no input is accepted, out_valid is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input tile is valid |
| in_ready | output | 1 | Unit can accept a tile |
| in_mode | input | 2 | 00 transpose, 01 even interleave, 10 odd interleave, 11 pass |
| in_row0 | input | 128 | Input row 0 |
| in_row1 | input | 128 | Input row 1 |
| in_row2 | input | 128 | Input row 2 |
| in_row3 | input | 128 | Input row 3 |
| out_valid | output | 1 | Output rows hold a result |
| out_ready | input | 1 | Consumer takes the result |
| out_row0 | output | 128 | Output row 0 |
| out_row1 | output | 128 | Output row 1 |
| out_row2 | output | 128 | Output row 2 |
| out_row3 | output | 128 | Output row 3 |

## Verification
The only internal state is the HOLD_EMPTY/HOLD_FULL flag and the result register. A wrong flag shows at the ports in the very next cycle: in_ready drops while the unit is empty, a result is lost during a stall, or out_valid stays high after a drain. A wrong lane select in the permutation shows in the first result of the mode that uses it. Each result is compared lane by lane with an index model in the bench, so one bad lane is enough to report the fault.

// File: rtl/lxp_pkg.sv
package lxp_pkg;
    typedef enum logic [1:0] {
        MODE_XPOSE = 2'b00,
        MODE_TRN_E = 2'b01,
        MODE_TRN_O = 2'b10,
        MODE_PASS  = 2'b11
    } mode_e;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_e;
endpackage

// File: rtl/lxp_permute.sv
module lxp_permute
    import lxp_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    parameter int ROWS   = 4,
    localparam int ROW_W = LANE_W * LANES
) (
    input  mode_e                         mode,
    input  logic [ROWS-1:0][ROW_W-1:0]    src,
    output logic [ROWS-1:0][ROW_W-1:0]    dst
);
    for (genvar n = 0; n < ROWS; n++) begin : g_row
        localparam int PART = n ^ 1;
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int TR = i % ROWS;
            localparam int TL = (i / ROWS) * ROWS + n;
            localparam int EV = (i / 2) * 2;
            localparam int OD = EV + 1;
            localparam int ER = (i % 2 == 0) ? n : PART;
            always_comb begin
                unique case (mode)
                    MODE_XPOSE: dst[n][i*LANE_W +: LANE_W] = src[TR][TL*LANE_W +: LANE_W];
                    MODE_TRN_E: dst[n][i*LANE_W +: LANE_W] = src[ER][EV*LANE_W +: LANE_W];
                    MODE_TRN_O: dst[n][i*LANE_W +: LANE_W] = src[ER][OD*LANE_W +: LANE_W];
                    MODE_PASS:  dst[n][i*LANE_W +: LANE_W] = src[n][i*LANE_W +: LANE_W];
                endcase
            end
        end
    end
endmodule

// File: rtl/lxp_ctrl.sv
module lxp_ctrl
    import lxp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    hold_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOLD_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_EMPTY: if (in_valid) state_d = HOLD_FULL;                 // FILL
            HOLD_FULL:  if (out_ready && !in_valid) state_d = HOLD_EMPTY;  // DRAIN
        endcase
    end

    always_comb begin
        unique case (state_q)
            HOLD_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            HOLD_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
        endcase
        load = in_valid && in_ready;
    end
endmodule

// File: rtl/lxp_hold.sv
module lxp_hold #(
    parameter int WIDTH = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/lane_xpose_unit.sv
module lane_xpose_unit
    import lxp_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 8,
    localparam int ROWS  = 4,
    localparam int ROW_W = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [1:0]       in_mode,
    input  logic [ROW_W-1:0] in_row0,
    input  logic [ROW_W-1:0] in_row1,
    input  logic [ROW_W-1:0] in_row2,
    input  logic [ROW_W-1:0] in_row3,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row0,
    output logic [ROW_W-1:0] out_row1,
    output logic [ROW_W-1:0] out_row2,
    output logic [ROW_W-1:0] out_row3
);
    logic [ROWS-1:0][ROW_W-1:0] src, perm, held;
    logic load;

    assign src = {in_row3, in_row2, in_row1, in_row0};

    lxp_permute #(.LANE_W(LANE_W), .LANES(LANES), .ROWS(ROWS)) u_perm (
        .mode (mode_e'(in_mode)),
        .src  (src),
        .dst  (perm)
    );

    lxp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    lxp_hold #(.WIDTH(ROWS*ROW_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .d     (perm),
        .q     (held)
    );

    assign out_row0 = held[0];
    assign out_row1 = held[1];
    assign out_row2 = held[2];
    assign out_row3 = held[3];
endmodule

// File: rtl/lxp_checker.sv
module lxp_checker #(
    parameter int ROW_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_mode,
    input logic [ROW_W-1:0] in_row0,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row0,
    input logic [ROW_W-1:0] out_row1,
    input logic [ROW_W-1:0] out_row2,
    input logic [ROW_W-1:0] out_row3
);
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R1

    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R3

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row0) && $stable(out_row1)
                                       && $stable(out_row2) && $stable(out_row3))); // R3

    AST_PASS_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode == 2'b11) |=> (out_row0 == $past(in_row0))); // R8

    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid); // R10
endmodule

bind lane_xpose_unit lxp_checker #(.ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mode   (in_mode),
    .in_row0   (in_row0),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row0  (out_row0),
    .out_row1  (out_row1),
    .out_row2  (out_row2),
    .out_row3  (out_row3)
);

// File: tb/lane_xpose_unit_bench.sv
`timescale 1ns/1ps
module lane_xpose_unit_bench;
    typedef logic [3:0][127:0] tile_t;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, out_ready = 1;
    logic [1:0] in_mode = 0;
    tile_t tin = '0;
    logic in_ready, out_valid;
    logic [127:0] o0, o1, o2, o3;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    lane_xpose_unit u_lane_xpose_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
        .in_row0(tin[0]), .in_row1(tin[1]), .in_row2(tin[2]), .in_row3(tin[3]),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_row0(o0), .out_row1(o1), .out_row2(o2), .out_row3(o3)
    );

    function automatic tile_t model(input logic [1:0] m, input tile_t t);
        tile_t o;
        logic [15:0] flat [32];
        for (int r = 0; r < 4; r++)
            for (int l = 0; l < 8; l++) flat[r*8+l] = t[r][l*16 +: 16];
        for (int n = 0; n < 4; n++)
            for (int i = 0; i < 8; i++) begin
                int k;
                case (m)
                    2'b00: o[n][i*16 +: 16] = flat[(i & 3) * 8 + (i & ~3) + n];
                    2'b01: begin k = (i / 2) * 2;
                        o[n][i*16 +: 16] = (i % 2 == 0) ? t[n][k*16 +: 16] : t[n ^ 1][k*16 +: 16]; end
                    2'b10: begin k = (i / 2) * 2 + 1;
                        o[n][i*16 +: 16] = (i % 2 == 0) ? t[n][k*16 +: 16] : t[n ^ 1][k*16 +: 16]; end
                    default: o[n][i*16 +: 16] = t[n][i*16 +: 16];
                endcase
            end
        return o;
    endfunction

    function automatic tile_t rnd_tile();
        tile_t t;
        for (int r = 0; r < 4; r++)
            for (int w = 0; w < 4; w++) t[r][w*32 +: 32] = $urandom;
        return t;
    endfunction

    function automatic tile_t got();
        return {o3, o2, o1, o0};
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, accept at posedge, leave the clock at the next negedge
    task automatic send(input logic [1:0] m, input tile_t t);
        @(negedge clk);
        in_mode = m; tin = t; in_valid = 1;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic run_one(input logic [1:0] m, input tile_t t, input string req);
        send(m, t);
        check("R2 out_valid", {511'b0, out_valid}, 512'd1);
        check(req, got(), model(m, t));
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tile_t a, b, first;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", {511'b0, out_valid}, 512'd0);
        check("R1 reset in_ready", {511'b0, in_ready}, 512'd1);
        rst_n = 1;

        // directed index tile: lane value = row*8+lane
        for (int r = 0; r < 4; r++)
            for (int l = 0; l < 8; l++) a[r][l*16 +: 16] = 16'(r*8 + l);
        run_one(2'b00, a, "R4 transpose index tile");
        run_one(2'b01, a, "R6 even interleave index tile");
        run_one(2'b10, a, "R7 odd interleave index tile");
        run_one(2'b11, a, "R8 pass index tile");

        for (int j = 0; j < 40; j++) begin
            a = rnd_tile();
            run_one(2'b00, a, "R4 transpose random");
            first = got();
            run_one(2'b00, first, "R9 transpose twice");
            check("R9 round trip", got(), a);
            run_one(2'b01, a, "R6 even interleave random");
            run_one(2'b10, a, "R7 odd interleave random");
            run_one(2'b11, a, "R8 pass random");
        end

        // R5: change only lanes 4-7 of the input, left output half must not move
        a = rnd_tile();
        run_one(2'b00, a, "R5 transpose base");
        first = got();
        b = a;
        for (int r = 0; r < 4; r++) b[r][127:64] = ~a[r][127:64];
        run_one(2'b00, b, "R5 transpose right changed");
        for (int r = 0; r < 4; r++)
            check("R5 left half unchanged", {448'b0, got()[r][63:0]}, {448'b0, first[r][63:0]});

        // R3 stall then R10 drain
        a = rnd_tile(); b = rnd_tile();
        @(negedge clk); out_ready = 0;
        send(2'b00, a);
        in_mode = 2'b01; tin = b; in_valid = 1;
        for (int c = 0; c < 3; c++) begin
            check("R3 in_ready low", {511'b0, in_ready}, 512'd0);
            check("R3 held", got(), model(2'b00, a));
            @(negedge clk);
        end
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        check("R3 next taken after stall", got(), model(2'b01, b));
        check("R3 valid after refill", {511'b0, out_valid}, 512'd1);
        @(negedge clk);
        check("R10 drained", {511'b0, out_valid}, 512'd0);
        check("R1 idle ready", {511'b0, in_ready}, 512'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule